// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a compact 32-bit processor that completes one instruction on every clock edge. It fetches a fixed-width 32-bit word from an internal instruction store and decodes it in one of three layouts: register, immediate or jump. All three layouts keep the opcode in bits 31:26. The register and immediate layouts also place the two source register indices at the same bit positions. The core then reads a 32-entry register file, runs the ALU, optionally reads or writes an internal word-addressed data store, and updates the program counter.

The instruction store and the data store are plain word arrays inside the top module. A test environment preloads the instruction store while reset is held. Once reset is released, execution starts at address 0 and continues until the core meets an encoding it does not recognise. At that point the core raises its halt output and stays stopped until the next reset. A combinational debug port reads any architectural register at any time.

Top module: `sc_core`

## Requirements
- R1: While reset is low and right after it is released, the program counter is 0 and every register reads 0 on the debug port.
- R2: With opcode 0 in bits 31:26, funct in bits 5:0 selects the operation and the result goes to rd (bits 15:11), computed from rs (bits 25:21) and rt (bits 20:16). The funct codes are add 32, sub 34, and 36, or 37 and nor 39.
- R3: With opcode 0, funct 0 shifts rt left logically and funct 2 shifts rt right logically, by the 5-bit amount in bits 10:6. The result goes to rd, and the rs field has no effect.
- R4: Opcode 8 writes rt with rs plus the 16-bit immediate in bits 15:0, after that immediate is sign-extended.
- R5: Funct 42 (register layout) and opcode 10 (immediate layout, sign-extended immediate) write 1 when the first operand is less than the second as signed values, and 0 otherwise.
- R6: Register 0 always reads 0, and any write aimed at it is dropped.
- R7: Opcode 43 stores rt to the data word at byte address rs plus the sign-extended immediate. Opcode 35 loads that word into rt. The word index is taken from address bits 2 and up.
- R8: Opcode 4 (equal) and opcode 5 (not equal) compare rs with rt. When the branch is taken, the next PC is PC+4 plus the sign-extended immediate times 4. Otherwise the next PC is PC+4.
- R9: Opcode 2 sets the PC to the top 4 bits of the current PC, followed by bits 25:0 of the instruction, followed by two zero bits.
- R10: An unknown opcode, or an unknown funct under opcode 0, raises halt in the same cycle. It holds the PC and writes neither a register nor memory, so the halt persists until reset.
- R11: The debug port returns the current value of the register it addresses without a clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dbg_addr_i | input | 5 | Register index for the debug read |
| dbg_data_o | output | 32 | Value of the addressed register |
| halt_o | output | 1 | Core is stopped on an unrecognised encoding |

## Verification
The bench targets the points where the layouts differ. If the destination select were wrong, immediate results would land in rd and corrupt an unrelated register. If a shift read rs instead of rt, the directed program would catch it, because that program places non-zero garbage in the shift's rs field. A signed comparison done as unsigned would flip the result when comparing -7 with 100. A branch offset that was not scaled by four, or that was added to PC instead of PC+4, would change the counted loop's iteration total and the number of cycles to halt. Writes to register 0 are aimed at it from both layouts. The halting encodings carry a live rd or rt field, so a halt that still wrote back would change a register. A PC that kept moving would show up as a wrong halt count or a later register change.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_J     = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_SLTI  = 6'd10;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_SLL = 6'd0;
  localparam logic [5:0] FN_SRL = 6'd2;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_NOR = 6'd39;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLT, ALU_SLL, ALU_SRL
  } alu_op_e;

  typedef struct packed {
    alu_op_e alu_op;
    logic    b_imm;
    logic    dst_rd;
    logic    reg_we;
    logic    mem_re;
    logic    mem_we;
    logic    branch;
    logic    br_ne;
    logic    jump;
    logic    illegal;
  } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_core_pkg::*;
(
  input  logic [31:0] instr_i,
  output ctrl_t       ctrl_o
);

  logic [5:0] op, fn;
  assign op = instr_i[31:26];
  assign fn = instr_i[5:0];

  ctrl_t c;

  always_comb begin
    c        = '0;
    c.alu_op = ALU_ADD;
    unique case (op)
      OP_RTYPE: begin
        c.dst_rd = 1'b1;
        c.reg_we = 1'b1;
        unique case (fn)
          FN_ADD:  c.alu_op = ALU_ADD;
          FN_SUB:  c.alu_op = ALU_SUB;
          FN_AND:  c.alu_op = ALU_AND;
          FN_OR:   c.alu_op = ALU_OR;
          FN_NOR:  c.alu_op = ALU_NOR;
          FN_SLT:  c.alu_op = ALU_SLT;
          FN_SLL:  c.alu_op = ALU_SLL;
          FN_SRL:  c.alu_op = ALU_SRL;
          default: c.illegal = 1'b1;
        endcase
      end
      OP_ADDI: begin
        c.b_imm  = 1'b1;
        c.reg_we = 1'b1;
      end
      OP_SLTI: begin
        c.b_imm  = 1'b1;
        c.reg_we = 1'b1;
        c.alu_op = ALU_SLT;
      end
      OP_LW: begin
        c.b_imm  = 1'b1;
        c.reg_we = 1'b1;
        c.mem_re = 1'b1;
      end
      OP_SW: begin
        c.b_imm  = 1'b1;
        c.mem_we = 1'b1;
      end
      OP_BEQ: c.branch = 1'b1;
      OP_BNE: begin
        c.branch = 1'b1;
        c.br_ne  = 1'b1;
      end
      OP_J:    c.jump    = 1'b1;
      default: c.illegal = 1'b1;
    endcase
    // an unknown encoding must have no side effect
    if (c.illegal) begin
      c.reg_we = 1'b0;
      c.mem_we = 1'b0;
      c.branch = 1'b0;
      c.jump   = 1'b0;
    end
  end

  assign ctrl_o = c;

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [SHW-1:0]  shamt_i,
  output logic [XLEN-1:0] y_o
);

  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_NOR: y_o = ~(a_i | b_i);
      ALU_SLT: y_o = {{(XLEN-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      ALU_SLL: y_o = b_i << shamt_i;
      ALU_SRL: y_o = b_i >> shamt_i;
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   ra_i,
  input  logic [AW-1:0]   rb_i,
  input  logic [AW-1:0]   rdbg_i,
  output logic [XLEN-1:0] da_o,
  output logic [XLEN-1:0] db_o,
  output logic [XLEN-1:0] ddbg_o,
  input  logic            we_i,
  input  logic [AW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i
);

  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign da_o   = regs_q[ra_i];
  assign db_o   = regs_q[rb_i];
  assign ddbg_o = regs_q[rdbg_i];

  // R6
  reg_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q[0] == '0);

  // R6
  reg_zero_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i == '0) |=> (da_o == '0 || ra_i != '0));

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NREG       = 32,
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 64,
  localparam int RAW = $clog2(NREG),
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int SHW = $clog2(XLEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RAW-1:0]  dbg_addr_i,
  output logic [XLEN-1:0] dbg_data_o,
  output logic            halt_o
);

  logic [31:0]     imem_q [IMEM_WORDS];
  logic [XLEN-1:0] dmem_q [DMEM_WORDS];

  initial begin
    for (int i = 0; i < IMEM_WORDS; i++) imem_q[i] = '0;
    for (int i = 0; i < DMEM_WORDS; i++) dmem_q[i] = '0;
  end

  logic [XLEN-1:0] pc_q, pc_d, pc_plus4;
  logic [31:0]     instr;
  ctrl_t           ctrl;

  assign instr = imem_q[pc_q[IAW+1:2]];

  sc_decode u_dec (
    .instr_i (instr),
    .ctrl_o  (ctrl)
  );

  logic [RAW-1:0]  rs, rt, rd, dst;
  logic [SHW-1:0]  shamt;
  logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, wb_val, ld_val;
  logic            rf_we, take;

  assign rs      = instr[25:21];
  assign rt      = instr[20:16];
  assign rd      = instr[15:11];
  assign shamt   = instr[10:6];
  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign dst     = ctrl.dst_rd ? rd : rt;

  sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (rs),
    .rb_i   (rt),
    .rdbg_i (dbg_addr_i),
    .da_o   (rs_val),
    .db_o   (rt_val),
    .ddbg_o (dbg_data_o),
    .we_i   (rf_we),
    .wa_i   (dst),
    .wd_i   (wb_val)
  );

  assign alu_b = ctrl.b_imm ? imm_ext : rt_val;

  sc_alu #(.XLEN(XLEN)) u_alu (
    .op_i    (ctrl.alu_op),
    .a_i     (rs_val),
    .b_i     (alu_b),
    .shamt_i (shamt),
    .y_o     (alu_y)
  );

  assign ld_val = dmem_q[alu_y[DAW+1:2]];
  assign wb_val = ctrl.mem_re ? ld_val : alu_y;
  assign rf_we  = ctrl.reg_we;

  always_ff @(posedge clk_i) begin
    if (rst_ni && ctrl.mem_we) dmem_q[alu_y[DAW+1:2]] <= rt_val;
  end

  assign take     = ctrl.branch && ((rs_val == rt_val) ^ ctrl.br_ne);
  assign pc_plus4 = pc_q + XLEN'(4);

  always_comb begin
    if (ctrl.illegal)   pc_d = pc_q;
    else if (ctrl.jump) pc_d = {pc_q[XLEN-1:28], instr[25:0], 2'b00};
    else if (take)      pc_d = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    else                pc_d = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign halt_o = ctrl.illegal;

  // R10
  halt_pc_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (halt_o && $stable(pc_q)));

  // R10
  halt_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (!rf_we && !ctrl.mem_we));

  // R9
  jump_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.jump |=> pc_q[27:0] == {$past(instr[25:0]), 2'b00});

  // R8
  branch_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.branch && !take) |=> pc_q == $past(pc_q) + XLEN'(4));

  // R8
  pc_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q[1:0] == 2'b00);

  // R7
  store_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.mem_we |-> !rf_we);

endmodule

// File: tb/sc_core_test.sv
module sc_core_test;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_data;
  logic        halt;

  always #5 clk = ~clk;

  sc_core uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .dbg_addr_i (dbg_addr),
    .dbg_data_o (dbg_data),
    .halt_o     (halt)
  );

  localparam logic [31:0] ILL = 32'hFC00_0000;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] prog  [256];
  logic [31:0] mreg  [32];
  logic [31:0] mdmem [64];
  logic [31:0] snap  [32];

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt,
                                        logic [4:0] rd, logic [4:0] sh);
    return {6'd0, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                        logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(logic [25:0] tgt);
    return {6'd2, tgt};
  endfunction

  task automatic mwr(logic [4:0] r, logic [31:0] v);
    if (r != 5'd0) mreg[r] = v;
  endtask

  // reference execution of prog[] from address 0
  task automatic model_run(output int steps);
    logic [31:0] pc, npc, ins, a, b, imm, ea;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, sh;
    bit          ill;
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    pc = '0;
    steps = 0;
    for (int k = 0; k < 4000; k++) begin
      ins = prog[pc[9:2]];
      op = ins[31:26]; fn = ins[5:0];
      rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; sh = ins[10:6];
      a = mreg[rs]; b = mreg[rt];
      imm = {{16{ins[15]}}, ins[15:0]};
      ea = a + imm;
      npc = pc + 32'd4;
      ill = 1'b0;
      case (op)
        6'd0: case (fn)
          6'd32: mwr(rd, a + b);
          6'd34: mwr(rd, a - b);
          6'd36: mwr(rd, a & b);
          6'd37: mwr(rd, a | b);
          6'd39: mwr(rd, ~(a | b));
          6'd42: mwr(rd, {31'd0, $signed(a) < $signed(b)});
          6'd0:  mwr(rd, b << sh);
          6'd2:  mwr(rd, b >> sh);
          default: ill = 1'b1;
        endcase
        6'd8:  mwr(rt, ea);
        6'd10: mwr(rt, {31'd0, $signed(a) < $signed(imm)});
        6'd35: mwr(rt, mdmem[ea[7:2]]);
        6'd43: mdmem[ea[7:2]] = b;
        6'd4:  if (a == b) npc = pc + 32'd4 + {imm[29:0], 2'b00};
        6'd5:  if (a != b) npc = pc + 32'd4 + {imm[29:0], 2'b00};
        6'd2:  npc = {pc[31:28], ins[25:0], 2'b00};
        default: ill = 1'b1;
      endcase
      if (ill) break;
      pc = npc;
      steps++;
    end
  endtask

  task automatic read_reg(input int r, output logic [31:0] v);
    dbg_addr = r[4:0];
    #1;
    v = dbg_data;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = ILL;
  endtask

  task automatic run_prog(string req);
    int steps, cnt;
    logic [31:0] v;
    model_run(steps);
    @(negedge clk);
    rst_ni = 1'b0;
    for (int i = 0; i < 256; i++) uut.imem_q[i] = prog[i];
    @(negedge clk);
    rst_ni = 1'b1;
    cnt = 0;
    while (!halt && cnt < 5000) begin
      @(negedge clk);
      cnt++;
    end
    // R10: halt rises exactly after the executed instruction count
    check("R10", "cycles to halt", cnt, steps);
    for (int r = 0; r < 32; r++) begin
      read_reg(r, v);
      check(req, $sformatf("reg %0d", r), v, mreg[r]);
    end
    repeat (8) @(negedge clk);
    check("R10", "halt held", {31'd0, halt}, 32'd1);
    for (int r = 1; r < 32; r++) begin
      read_reg(r, v);
      check("R10", $sformatf("reg %0d frozen", r), v, mreg[r]);
    end
  endtask

  task automatic gen_random(int len);
    logic [4:0]  rs, rt, rd;
    logic [15:0] imm;
    int          sel;
    logic [5:0]  fns [8];
    fns = '{6'd32, 6'd34, 6'd36, 6'd37, 6'd39, 6'd42, 6'd0, 6'd2};
    clear_prog();
    for (int i = 0; i < len; i++) begin
      rs  = 5'($urandom % 32);
      rt  = 5'($urandom % 32);
      rd  = 5'($urandom % 32);
      imm = 16'($urandom);
      sel = int'($urandom % 10);
      case (sel)
        0, 1, 2: prog[i] = enc_r(fns[$urandom % 8], rs, rt, rd, 5'($urandom));
        3, 4:    prog[i] = enc_i(6'd8, rs, rt, imm);
        5:       prog[i] = enc_i(6'd10, rs, rt, imm);
        6:       prog[i] = enc_i(6'd43, 5'd0, rt, 16'(4 * ($urandom % 64)));
        7:       prog[i] = enc_i(6'd35, 5'd0, rt, 16'(4 * ($urandom % 64)));
        8:       prog[i] = enc_i(6'd4, rs, rt, 16'($urandom % 3));
        default: prog[i] = enc_i(6'd5, rs, rt, 16'($urandom % 3));
      endcase
    end
  endtask

  initial begin
    #(10 * 150000);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) mdmem[i] = '0;

    // R1: reset state, instruction store holds legal no-ops
    repeat (3) @(negedge clk);
    for (int r = 0; r < 32; r++) begin
      read_reg(r, v);
      check("R1", $sformatf("reset reg %0d", r), v, 32'd0);
    end
    check("R1", "halt in reset", {31'd0, halt}, 32'd0);
    // R11: debug port is combinational, reads r0 right after address change
    read_reg(0, v);
    check("R11", "dbg r0", v, 32'd0);

    // R2 R5 R6
    clear_prog();
    prog[0]  = enc_i(6'd8, 5'd0, 5'd1, 16'hFFF9);
    prog[1]  = enc_i(6'd8, 5'd0, 5'd2, 16'd100);
    prog[2]  = enc_r(6'd32, 5'd1, 5'd2, 5'd3, 5'd0);
    prog[3]  = enc_r(6'd34, 5'd1, 5'd2, 5'd4, 5'd0);
    prog[4]  = enc_r(6'd36, 5'd1, 5'd2, 5'd5, 5'd0);
    prog[5]  = enc_r(6'd37, 5'd1, 5'd2, 5'd6, 5'd0);
    prog[6]  = enc_r(6'd39, 5'd1, 5'd2, 5'd7, 5'd0);
    prog[7]  = enc_r(6'd42, 5'd1, 5'd2, 5'd8, 5'd0);
    prog[8]  = enc_r(6'd42, 5'd2, 5'd1, 5'd9, 5'd0);
    prog[9]  = enc_i(6'd10, 5'd1, 5'd10, 16'hFFF8);
    prog[10] = enc_i(6'd10, 5'd1, 5'd11, 16'd5);
    prog[11] = enc_i(6'd8, 5'd2, 5'd0, 16'd5);
    prog[12] = enc_r(6'd32, 5'd2, 5'd2, 5'd0, 5'd0);
    prog[13] = enc_r(6'd32, 5'd0, 5'd2, 5'd12, 5'd0);
    run_prog("R2 R5 R6");
    read_reg(8, v);
    check("R5", "slt -7<100", v, 32'd1);
    read_reg(11, v);
    check("R5", "slti -7<5", v, 32'd1);
    read_reg(0, v);
    check("R6", "r0 after writes", v, 32'd0);
    read_reg(3, v);
    check("R2", "add", v, 32'd93);
    read_reg(1, v);
    check("R4", "addi negative", v, 32'hFFFF_FFF9);

    // R3: shifts with garbage in rs
    clear_prog();
    prog[0] = enc_i(6'd8, 5'd0, 5'd1, 16'h8000);
    prog[1] = enc_i(6'd8, 5'd0, 5'd9, 16'd3);
    prog[2] = enc_r(6'd0, 5'd9, 5'd1, 5'd2, 5'd4);
    prog[3] = enc_r(6'd2, 5'd9, 5'd1, 5'd3, 5'd31);
    prog[4] = enc_r(6'd0, 5'd9, 5'd1, 5'd4, 5'd0);
    prog[5] = enc_r(6'd2, 5'd9, 5'd1, 5'd5, 5'd16);
    run_prog("R3");
    read_reg(2, v);
    check("R3", "sll 4", v, 32'hFFF8_0000);
    read_reg(5, v);
    check("R3", "srl 16", v, 32'h0000_FFFF);

    // R7
    clear_prog();
    prog[0] = enc_i(6'd8, 5'd0, 5'd1, 16'd64);
    prog[1] = enc_i(6'd8, 5'd0, 5'd2, 16'h1234);
    prog[2] = enc_i(6'd43, 5'd1, 5'd2, 16'hFFF8);
    prog[3] = enc_i(6'd35, 5'd1, 5'd3, 16'hFFF8);
    prog[4] = enc_i(6'd43, 5'd0, 5'd1, 16'd4);
    prog[5] = enc_i(6'd35, 5'd0, 5'd4, 16'd4);
    prog[6] = enc_i(6'd35, 5'd0, 5'd5, 16'd56);
    run_prog("R7");
    read_reg(5, v);
    check("R7", "load from 56", v, 32'h1234);

    // R8 R9
    clear_prog();
    prog[0]  = enc_i(6'd8, 5'd0, 5'd1, 16'd3);
    prog[1]  = enc_i(6'd8, 5'd2, 5'd2, 16'd1);
    prog[2]  = enc_i(6'd8, 5'd1, 5'd1, 16'hFFFF);
    prog[3]  = enc_i(6'd5, 5'd1, 5'd0, 16'hFFFD);
    prog[4]  = enc_i(6'd4, 5'd0, 5'd0, 16'd1);
    prog[5]  = enc_i(6'd8, 5'd0, 5'd3, 16'd99);
    prog[6]  = enc_i(6'd8, 5'd0, 5'd4, 16'd7);
    prog[7]  = enc_i(6'd4, 5'd4, 5'd0, 16'd1);
    prog[8]  = enc_i(6'd5, 5'd4, 5'd4, 16'd1);
    prog[9]  = enc_i(6'd8, 5'd0, 5'd7, 16'd1);
    prog[10] = enc_j(26'd12);
    prog[11] = enc_i(6'd8, 5'd0, 5'd5, 16'd55);
    prog[12] = enc_i(6'd8, 5'd0, 5'd6, 16'd66);
    run_prog("R8 R9");
    read_reg(2, v);
    check("R8", "loop count", v, 32'd3);
    read_reg(3, v);
    check("R8", "taken skip", v, 32'd0);
    read_reg(7, v);
    check("R8", "not taken falls", v, 32'd1);
    read_reg(5, v);
    check("R9", "jump skip", v, 32'd0);
    read_reg(6, v);
    check("R9", "jump target", v, 32'd66);

    // R10: illegal funct carrying rd, then illegal opcode carrying rt
    clear_prog();
    prog[0] = enc_i(6'd8, 5'd0, 5'd5, 16'd9);
    prog[1] = enc_r(6'd1, 5'd5, 5'd5, 5'd5, 5'd0);
    run_prog("R10");
    read_reg(5, v);
    check("R10", "no wb on bad funct", v, 32'd9);
    clear_prog();
    prog[0] = enc_i(6'd8, 5'd0, 5'd6, 16'd4);
    prog[1] = enc_i(6'd9, 5'd6, 5'd6, 16'd100);
    run_prog("R10");

    // random programs: R2 R3 R4 R5 R7 R8
    for (int p = 0; p < 8; p++) begin
      gen_random(40);
      run_prog("R4 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule